// File: doc/BRIEF.md
# Router Switch Traversal Stage

This block is the crossbar-traversal step of a virtual-channel router pipeline. Each input port owns one crossbar slot. An earlier allocation step fills the slot with a granted input VC. In the cycle a slot is valid, the stage checks that the move is legal. It then pops the head flit of that VC and sends the flit to the output recorded in the VC's state. That output is either an outgoing link pipeline, where the flit carries its output VC, or one of the local ejection ports toward the network interface.

Every completed traversal also does three things. It frees the crossbar input slot and the crossbar output port. It sends one credit back to the upstream router after a fixed link delay. On a tail flit, it returns both the input VC and the reserved output VC to idle.

All inputs are handled in the same cycle. A traversal that would break a router invariant does not update anything and raises an error flag instead.

All results are registered and appear one clock after the inputs are sampled. The outputs are pulses that the surrounding router applies to its buffers, link pipelines, network-interface writers and state tables.

Top module: `switch_traverse_stage`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output is zero.
- R2: Only an input whose slot is valid can traverse. A valid slot whose selected VC buffer is empty causes no action for that input and sets `err`.
- R3: An input that traverses shows `pop_valid[i]=1` and the popped VC on `pop_vc` in the cycle after the slot is presented. Unused `pop_vc` fields read zero.
- R4: When the recorded output port is below NUM_INT, the flit is pushed onto that link. `link_push`, `link_data`, `link_tail` and `link_vc` carry the flit and its recorded output VC, and each is zero on links that carry no flit.
- R5: When the recorded output port p is NUM_INT or above, the flit goes to ejection interface p-NUM_INT through `ej_write`, `ej_data` and `ej_tail`. `eject_count` gives the number of flits that leave the router this way in the cycle.
- R6: A flit bound for a link whose occupancy is at or above LINK_DELAY*LINK_LAT does not move, and `err` is set.
- R7: Each traversal raises `xb_clear[i]` for its input slot and `port_free[p]` for its output port.
- R8: A tail flit raises `ivc_release[i]` and `ovc_release[p*NUM_VC+ovc]`. A body flit raises neither.
- R9: Each traversal from an input with `has_upstream[i]=1` produces `cred_valid[i]` with the popped VC on `cred_vc`. This appears exactly LINK_DELAY*LINK_LAT cycles after the pop is shown. No credit is produced without an upstream router.
- R10: `pass_count` equals the number of traversals in the cycle.
- R11: An input is blocked and `err` is set in any of these cases: the selected VC is not active, the recorded port number is not below NUM_PORTS, the output port is not marked busy, or a tail flit's output VC is not reserved. If two otherwise legal inputs name the same output port, both are blocked and `err` is set.
- R12: Inputs are independent. Any number of legal inputs traverse in the same cycle, and a blocked input does not stop the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xb_valid | input | NUM_PORTS | Crossbar slot holds a granted VC, per input |
| xb_vc | input | NUM_PORTS*VCW | Granted VC per input slot |
| buf_empty | input | NUM_PORTS*NUM_VC | VC buffer empty, index i*NUM_VC+v |
| head_data | input | NUM_PORTS*NUM_VC*DATA_W | Head flit payload of each VC buffer |
| head_tail | input | NUM_PORTS*NUM_VC | Head flit is a packet tail |
| ivc_active | input | NUM_PORTS*NUM_VC | Input VC is in the active state |
| ivc_port | input | NUM_PORTS*NUM_VC*PW | Recorded output port of each input VC |
| ivc_ovc | input | NUM_PORTS*NUM_VC*VCW | Recorded output VC of each input VC |
| outport_busy | input | NUM_PORTS | Crossbar output port is busy |
| link_occ | input | NUM_INT*OCW | Flits now in each outgoing link pipeline |
| ovc_reserved | input | NUM_PORTS*NUM_VC | Output VC reserved, index p*NUM_VC+v |
| has_upstream | input | NUM_PORTS | An upstream router feeds this input |
| pop_valid | output | NUM_PORTS | Pop the granted VC buffer |
| pop_vc | output | NUM_PORTS*VCW | VC to pop |
| link_push | output | NUM_INT | Push a flit onto the link pipeline |
| link_data | output | NUM_INT*DATA_W | Pushed payload |
| link_tail | output | NUM_INT | Pushed flit is a tail |
| link_vc | output | NUM_INT*VCW | Output VC tag of the pushed flit |
| ej_write | output | NUM_PORTS-NUM_INT | Write to an ejection interface |
| ej_data | output | (NUM_PORTS-NUM_INT)*DATA_W | Ejected payload |
| ej_tail | output | NUM_PORTS-NUM_INT | Ejected flit is a tail |
| cred_valid | output | NUM_PORTS | Credit toward the upstream router |
| cred_vc | output | NUM_PORTS*VCW | VC the credit belongs to |
| xb_clear | output | NUM_PORTS | Invalidate the crossbar slot |
| port_free | output | NUM_PORTS | Mark the crossbar output port free |
| ivc_release | output | NUM_PORTS | Return the popped input VC to idle |
| ovc_release | output | NUM_PORTS*NUM_VC | Return an output VC to idle |
| pass_count | output | PCW | Traversals this cycle |
| eject_count | output | ECW | Flits leaving by ejection this cycle |
| err | output | 1 | An invariant check blocked at least one input |

## Verification
A link push and an ejection can happen in the same cycle, and a blocked input can sit beside inputs that go ahead. The directed cases create both situations. One case sends all six inputs at once, two of them to the ejection ports and one of those carrying a tail. Another case has two inputs claim the same port while a third input stays legal.

Random cycles then mix link, eject, tail, collision and fault conditions with a fixed seed. A bench model built from the requirements predicts every output vector for each cycle, and also the delayed credit vector D cycles later. Each prediction is compared against the DUT outputs in full.

// File: rtl/st_pkg.sv
package st_pkg;

    // index width that never collapses to zero
    function automatic int st_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // why one input may not traverse, in check priority
    typedef enum logic [2:0] {
        FLT_NONE,
        FLT_EMPTY,
        FLT_IDLE_VC,
        FLT_BAD_PORT,
        FLT_PORT_FREE,
        FLT_LINK_FULL,
        FLT_NO_OVC
    } st_fault_e;

endpackage

// File: rtl/st_lane_check.sv
module st_lane_check
    import st_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int NUM_INT   = 4,
    parameter int NUM_VC    = 2,
    parameter int DATA_W    = 16,
    parameter int LINK_CAP  = 3,
    localparam int VCW = st_w(NUM_VC),
    localparam int PW  = st_w(NUM_PORTS),
    localparam int OCW = st_w(LINK_CAP + 1)
) (
    input  logic                       slot_valid,
    input  logic [VCW-1:0]             slot_vc,
    input  logic [NUM_VC-1:0]          buf_empty,
    input  logic [NUM_VC*DATA_W-1:0]   head_data,
    input  logic [NUM_VC-1:0]          head_tail,
    input  logic [NUM_VC-1:0]          vc_active,
    input  logic [NUM_VC*PW-1:0]       vc_port,
    input  logic [NUM_VC*VCW-1:0]      vc_ovc,
    input  logic [NUM_PORTS-1:0]       port_busy,
    input  logic [NUM_INT*OCW-1:0]     link_occ,
    input  logic [NUM_PORTS*NUM_VC-1:0] ovc_reserved,
    output logic                       eligible,
    output st_fault_e                  fault,
    output logic [PW-1:0]              dst_port,
    output logic [VCW-1:0]             dst_ovc,
    output logic [DATA_W-1:0]          flit_data,
    output logic                       flit_tail
);

    logic           sel_empty;
    logic           sel_act;
    logic           port_ok;
    logic           busy;
    logic           occ_full;
    logic           res_ok;
    logic [OCW-1:0] occ_pad [NUM_PORTS];

    // ejection ports carry no link pipeline: treat them as empty
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_occ
        if (p < NUM_INT) begin : g_link
            assign occ_pad[p] = link_occ[p*OCW +: OCW];
        end else begin : g_ej
            assign occ_pad[p] = '0;
        end
    end

    // pick the granted VC's buffer head and recorded route
    always_comb begin
        sel_empty = 1'b1;
        sel_act   = 1'b0;
        flit_data = '0;
        flit_tail = 1'b0;
        dst_port  = '0;
        dst_ovc   = '0;
        for (int k = 0; k < NUM_VC; k++) begin
            if (slot_vc == VCW'(k)) begin
                sel_empty = buf_empty[k];
                sel_act   = vc_active[k];
                flit_data = head_data[k*DATA_W +: DATA_W];
                flit_tail = head_tail[k];
                dst_port  = vc_port[k*PW +: PW];
                dst_ovc   = vc_ovc[k*VCW +: VCW];
            end
        end
    end

    // look up the destination port's crossbar, link and VC state
    always_comb begin
        port_ok  = 1'b0;
        busy     = 1'b0;
        occ_full = 1'b0;
        res_ok   = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dst_port == PW'(p)) begin
                port_ok  = 1'b1;
                busy     = port_busy[p];
                occ_full = (occ_pad[p] >= OCW'(LINK_CAP));
                for (int q = 0; q < NUM_VC; q++) begin
                    if (dst_ovc == VCW'(q)) begin
                        res_ok = ovc_reserved[p*NUM_VC + q];
                    end
                end
            end
        end
    end

    always_comb begin
        if (!slot_valid)              fault = FLT_NONE;
        else if (sel_empty)           fault = FLT_EMPTY;
        else if (!sel_act)            fault = FLT_IDLE_VC;
        else if (!port_ok)            fault = FLT_BAD_PORT;
        else if (!busy)               fault = FLT_PORT_FREE;
        else if (occ_full)            fault = FLT_LINK_FULL;
        else if (flit_tail && !res_ok) fault = FLT_NO_OVC;
        else                          fault = FLT_NONE;
    end

    assign eligible = slot_valid && (fault == FLT_NONE);

endmodule

// File: rtl/st_port_steer.sv
module st_port_steer
    import st_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int NUM_VC    = 2,
    parameter int DATA_W    = 16,
    parameter int PORT_ID   = 0,
    localparam int VCW = st_w(NUM_VC),
    localparam int PW  = st_w(NUM_PORTS)
) (
    input  logic [NUM_PORTS-1:0] go,
    input  logic [PW-1:0]        dst_port  [NUM_PORTS],
    input  logic [VCW-1:0]       dst_ovc   [NUM_PORTS],
    input  logic [DATA_W-1:0]    flit_data [NUM_PORTS],
    input  logic [NUM_PORTS-1:0] flit_tail,
    output logic                 hit,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_tail,
    output logic [VCW-1:0]       out_vc,
    output logic [NUM_VC-1:0]    rel_vc
);

    // collisions were removed upstream, so at most one input matches
    always_comb begin
        hit      = 1'b0;
        out_data = '0;
        out_tail = 1'b0;
        out_vc   = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (go[i] && dst_port[i] == PW'(PORT_ID)) begin
                hit      = 1'b1;
                out_data = out_data | flit_data[i];
                out_tail = out_tail | flit_tail[i];
                out_vc   = out_vc | dst_ovc[i];
            end
        end
    end

    always_comb begin
        for (int q = 0; q < NUM_VC; q++) begin
            rel_vc[q] = hit && out_tail && (out_vc == VCW'(q));
        end
    end

endmodule

// File: rtl/st_credit_pipe.sv
module st_credit_pipe #(
    parameter int DEPTH = 3,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    if (DEPTH == 0) begin : g_pass
        assign q = d;
    end else begin : g_pipe
        logic [WIDTH-1:0] stg [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < DEPTH; s++) stg[s] <= '0;
            end else begin
                stg[0] <= d;
                for (int s = 1; s < DEPTH; s++) stg[s] <= stg[s-1];
            end
        end
        assign q = stg[DEPTH-1];
    end

endmodule

// File: rtl/switch_traverse_stage.sv
module switch_traverse_stage
    import st_pkg::*;
#(
    parameter int NUM_PORTS  = 6,
    parameter int NUM_INT    = 4,
    parameter int NUM_VC     = 2,
    parameter int DATA_W     = 16,
    parameter int LINK_DELAY = 1,
    parameter int LINK_LAT   = 3,
    localparam int NUM_EJ   = NUM_PORTS - NUM_INT,
    localparam int LINK_CAP = LINK_DELAY * LINK_LAT,
    localparam int VCW      = st_w(NUM_VC),
    localparam int PW       = st_w(NUM_PORTS),
    localparam int OCW      = st_w(LINK_CAP + 1),
    localparam int PCW      = st_w(NUM_PORTS + 1),
    localparam int ECW      = st_w(NUM_EJ + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_PORTS-1:0]              xb_valid,
    input  logic [NUM_PORTS*VCW-1:0]          xb_vc,
    input  logic [NUM_PORTS*NUM_VC-1:0]       buf_empty,
    input  logic [NUM_PORTS*NUM_VC*DATA_W-1:0] head_data,
    input  logic [NUM_PORTS*NUM_VC-1:0]       head_tail,
    input  logic [NUM_PORTS*NUM_VC-1:0]       ivc_active,
    input  logic [NUM_PORTS*NUM_VC*PW-1:0]    ivc_port,
    input  logic [NUM_PORTS*NUM_VC*VCW-1:0]   ivc_ovc,
    input  logic [NUM_PORTS-1:0]              outport_busy,
    input  logic [NUM_INT*OCW-1:0]            link_occ,
    input  logic [NUM_PORTS*NUM_VC-1:0]       ovc_reserved,
    input  logic [NUM_PORTS-1:0]              has_upstream,
    output logic [NUM_PORTS-1:0]              pop_valid,
    output logic [NUM_PORTS*VCW-1:0]          pop_vc,
    output logic [NUM_INT-1:0]                link_push,
    output logic [NUM_INT*DATA_W-1:0]         link_data,
    output logic [NUM_INT-1:0]                link_tail,
    output logic [NUM_INT*VCW-1:0]            link_vc,
    output logic [NUM_EJ-1:0]                 ej_write,
    output logic [NUM_EJ*DATA_W-1:0]          ej_data,
    output logic [NUM_EJ-1:0]                 ej_tail,
    output logic [NUM_PORTS-1:0]              cred_valid,
    output logic [NUM_PORTS*VCW-1:0]          cred_vc,
    output logic [NUM_PORTS-1:0]              xb_clear,
    output logic [NUM_PORTS-1:0]              port_free,
    output logic [NUM_PORTS-1:0]              ivc_release,
    output logic [NUM_PORTS*NUM_VC-1:0]       ovc_release,
    output logic [PCW-1:0]                    pass_count,
    output logic [ECW-1:0]                    eject_count,
    output logic                              err
);

    localparam int CRW = NUM_PORTS * (1 + VCW);

    // per-input lane results
    logic [NUM_PORTS-1:0] elig;
    logic [NUM_PORTS-1:0] coll;
    logic [NUM_PORTS-1:0] go;
    logic [NUM_PORTS-1:0] tail_v;
    st_fault_e            fault [NUM_PORTS];
    logic [PW-1:0]        dport [NUM_PORTS];
    logic [VCW-1:0]       dovc  [NUM_PORTS];
    logic [DATA_W-1:0]    fdata [NUM_PORTS];

    // per-output steering results
    logic [NUM_PORTS-1:0] hit;
    logic [DATA_W-1:0]    sdata [NUM_PORTS];
    logic [NUM_PORTS-1:0] stail;
    logic [VCW-1:0]       sovc  [NUM_PORTS];
    logic [NUM_VC-1:0]    srel  [NUM_PORTS];

    // next-state values
    logic [NUM_PORTS*VCW-1:0]    pop_vc_d;
    logic [NUM_INT*DATA_W-1:0]   link_data_d;
    logic [NUM_INT-1:0]          link_push_d;
    logic [NUM_INT-1:0]          link_tail_d;
    logic [NUM_INT*VCW-1:0]      link_vc_d;
    logic [NUM_EJ-1:0]           ej_write_d;
    logic [NUM_EJ*DATA_W-1:0]    ej_data_d;
    logic [NUM_EJ-1:0]           ej_tail_d;
    logic [NUM_PORTS*NUM_VC-1:0] ovc_release_d;
    logic                        err_d;
    logic [CRW-1:0]              cred_d;
    logic [CRW-1:0]              cred_q;
    logic [CRW-1:0]              cred_out;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_lane
        st_lane_check #(
            .NUM_PORTS (NUM_PORTS),
            .NUM_INT   (NUM_INT),
            .NUM_VC    (NUM_VC),
            .DATA_W    (DATA_W),
            .LINK_CAP  (LINK_CAP)
        ) u_lane (
            .slot_valid   (xb_valid[i]),
            .slot_vc      (xb_vc[i*VCW +: VCW]),
            .buf_empty    (buf_empty[i*NUM_VC +: NUM_VC]),
            .head_data    (head_data[i*NUM_VC*DATA_W +: NUM_VC*DATA_W]),
            .head_tail    (head_tail[i*NUM_VC +: NUM_VC]),
            .vc_active    (ivc_active[i*NUM_VC +: NUM_VC]),
            .vc_port      (ivc_port[i*NUM_VC*PW +: NUM_VC*PW]),
            .vc_ovc       (ivc_ovc[i*NUM_VC*VCW +: NUM_VC*VCW]),
            .port_busy    (outport_busy),
            .link_occ     (link_occ),
            .ovc_reserved (ovc_reserved),
            .eligible     (elig[i]),
            .fault        (fault[i]),
            .dst_port     (dport[i]),
            .dst_ovc      (dovc[i]),
            .flit_data    (fdata[i]),
            .flit_tail    (tail_v[i])
        );
        assign pop_vc_d[i*VCW +: VCW] = go[i] ? xb_vc[i*VCW +: VCW] : '0;
        assign cred_d[i]                       = go[i] && has_upstream[i];
        assign cred_d[NUM_PORTS + i*VCW +: VCW] =
            (go[i] && has_upstream[i]) ? xb_vc[i*VCW +: VCW] : '0;
    end

    // two legal inputs naming the same output both stand down
    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            coll[i] = 1'b0;
            for (int j = 0; j < NUM_PORTS; j++) begin
                if (j != i && elig[i] && elig[j] && dport[i] == dport[j]) begin
                    coll[i] = 1'b1;
                end
            end
        end
    end

    assign go = elig & ~coll;

    always_comb begin
        err_d = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (fault[i] != FLT_NONE || coll[i]) err_d = 1'b1;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        st_port_steer #(
            .NUM_PORTS (NUM_PORTS),
            .NUM_VC    (NUM_VC),
            .DATA_W    (DATA_W),
            .PORT_ID   (p)
        ) u_steer (
            .go        (go),
            .dst_port  (dport),
            .dst_ovc   (dovc),
            .flit_data (fdata),
            .flit_tail (tail_v),
            .hit       (hit[p]),
            .out_data  (sdata[p]),
            .out_tail  (stail[p]),
            .out_vc    (sovc[p]),
            .rel_vc    (srel[p])
        );
        assign ovc_release_d[p*NUM_VC +: NUM_VC] = srel[p];

        if (p < NUM_INT) begin : g_link
            assign link_push_d[p]              = hit[p];
            assign link_data_d[p*DATA_W +: DATA_W] = sdata[p];
            assign link_tail_d[p]              = stail[p];
            assign link_vc_d[p*VCW +: VCW]     = sovc[p];
        end else begin : g_eject
            // ejection interface index is port number minus internal ports
            localparam int EI = p - NUM_INT;
            assign ej_write_d[EI]                = hit[p];
            assign ej_data_d[EI*DATA_W +: DATA_W] = sdata[p];
            assign ej_tail_d[EI]                 = stail[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_valid   <= '0;
            pop_vc      <= '0;
            link_push   <= '0;
            link_data   <= '0;
            link_tail   <= '0;
            link_vc     <= '0;
            ej_write    <= '0;
            ej_data     <= '0;
            ej_tail     <= '0;
            xb_clear    <= '0;
            port_free   <= '0;
            ivc_release <= '0;
            ovc_release <= '0;
            pass_count  <= '0;
            eject_count <= '0;
            err         <= 1'b0;
            cred_q      <= '0;
        end else begin
            pop_valid   <= go;
            pop_vc      <= pop_vc_d;
            link_push   <= link_push_d;
            link_data   <= link_data_d;
            link_tail   <= link_tail_d;
            link_vc     <= link_vc_d;
            ej_write    <= ej_write_d;
            ej_data     <= ej_data_d;
            ej_tail     <= ej_tail_d;
            xb_clear    <= go;
            port_free   <= hit;
            ivc_release <= go & tail_v;
            ovc_release <= ovc_release_d;
            pass_count  <= PCW'($countones(go));
            eject_count <= ECW'($countones(ej_write_d));
            err         <= err_d;
            cred_q      <= cred_d;
        end
    end

    // credit travels back over the link delay, counted from the pop
    st_credit_pipe #(
        .DEPTH (LINK_CAP),
        .WIDTH (CRW)
    ) u_cred (
        .clk (clk),
        .rst (rst),
        .d   (cred_q),
        .q   (cred_out)
    );

    assign cred_valid = cred_out[NUM_PORTS-1:0];
    assign cred_vc    = cred_out[CRW-1:NUM_PORTS];

endmodule

// File: rtl/switch_traverse_chk.sv
module switch_traverse_chk
    import st_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int NUM_INT   = 4,
    parameter int NUM_VC    = 2,
    localparam int NUM_EJ = NUM_PORTS - NUM_INT,
    localparam int VCW    = st_w(NUM_VC),
    localparam int PCW    = st_w(NUM_PORTS + 1),
    localparam int ECW    = st_w(NUM_EJ + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_PORTS-1:0]     xb_valid,
    input logic [NUM_PORTS*VCW-1:0] xb_vc,
    input logic [NUM_PORTS-1:0]     pop_valid,
    input logic [NUM_PORTS*VCW-1:0] pop_vc,
    input logic [NUM_PORTS-1:0]     ivc_release,
    input logic [NUM_INT-1:0]       link_push,
    input logic [NUM_EJ-1:0]        ej_write,
    input logic [NUM_PORTS-1:0]     port_free,
    input logic [PCW-1:0]           pass_count,
    input logic [ECW-1:0]           eject_count,
    input logic                     err
);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
        // R3
        pop_source_chk: assert property (@(posedge clk) disable iff (rst)
            pop_valid[i] |-> ($past(xb_valid[i]) &&
                              pop_vc[i*VCW +: VCW] == $past(xb_vc[i*VCW +: VCW])));
        // R8
        release_pop_chk: assert property (@(posedge clk) disable iff (rst)
            ivc_release[i] |-> pop_valid[i]);
    end

    // R10
    pass_sum_chk: assert property (@(posedge clk) disable iff (rst)
        32'(pass_count) == $countones(link_push) + $countones(ej_write));

    // R5
    eject_sum_chk: assert property (@(posedge clk) disable iff (rst)
        32'(eject_count) == $countones(ej_write));

    // R7
    free_sum_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(port_free) == $countones(pop_valid));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(|xb_valid) |-> (pass_count == '0 && !err));

endmodule

bind switch_traverse_stage switch_traverse_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_INT   (NUM_INT),
    .NUM_VC    (NUM_VC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .xb_valid    (xb_valid),
    .xb_vc       (xb_vc),
    .pop_valid   (pop_valid),
    .pop_vc      (pop_vc),
    .ivc_release (ivc_release),
    .link_push   (link_push),
    .ej_write    (ej_write),
    .port_free   (port_free),
    .pass_count  (pass_count),
    .eject_count (eject_count),
    .err         (err)
);

// File: tb/switch_traverse_stage_tb.sv
module switch_traverse_stage_tb;

    localparam int NP   = 6;
    localparam int NINT = 4;
    localparam int NEJ  = NP - NINT;
    localparam int NV   = 2;
    localparam int DW   = 16;
    localparam int LD   = 1;
    localparam int LL   = 3;
    localparam int CAP  = LD * LL;
    localparam int VCW  = 1;
    localparam int PW   = 3;
    localparam int OCW  = 2;
    localparam int PCW  = 3;
    localparam int ECW  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NP-1:0]        xb_valid;
    logic [NP*VCW-1:0]    xb_vc;
    logic [NP*NV-1:0]     buf_empty;
    logic [NP*NV*DW-1:0]  head_data;
    logic [NP*NV-1:0]     head_tail;
    logic [NP*NV-1:0]     ivc_active;
    logic [NP*NV*PW-1:0]  ivc_port;
    logic [NP*NV*VCW-1:0] ivc_ovc;
    logic [NP-1:0]        outport_busy;
    logic [NINT*OCW-1:0]  link_occ;
    logic [NP*NV-1:0]     ovc_reserved;
    logic [NP-1:0]        has_upstream;
    logic [NP-1:0]        pop_valid;
    logic [NP*VCW-1:0]    pop_vc;
    logic [NINT-1:0]      link_push;
    logic [NINT*DW-1:0]   link_data;
    logic [NINT-1:0]      link_tail;
    logic [NINT*VCW-1:0]  link_vc;
    logic [NEJ-1:0]       ej_write;
    logic [NEJ*DW-1:0]    ej_data;
    logic [NEJ-1:0]       ej_tail;
    logic [NP-1:0]        cred_valid;
    logic [NP*VCW-1:0]    cred_vc;
    logic [NP-1:0]        xb_clear;
    logic [NP-1:0]        port_free;
    logic [NP-1:0]        ivc_release;
    logic [NP*NV-1:0]     ovc_release;
    logic [PCW-1:0]       pass_count;
    logic [ECW-1:0]       eject_count;
    logic                 err;

    switch_traverse_stage #(
        .NUM_PORTS (NP), .NUM_INT (NINT), .NUM_VC (NV), .DATA_W (DW),
        .LINK_DELAY (LD), .LINK_LAT (LL)
    ) u_dut (.*);

    int n_chk  = 0;
    int n_fail = 0;

    // stimulus description
    bit          s_xv [NP];
    int          s_xvc [NP];
    bit          s_empty [NP][NV];
    logic [DW-1:0] s_data [NP][NV];
    bit          s_tail [NP][NV];
    bit          s_act [NP][NV];
    int          s_port [NP][NV];
    int          s_ovc [NP][NV];
    bit          s_busy [NP];
    int          s_occ [NINT];
    bit          s_res [NP][NV];
    bit          s_up [NP];

    // expected values
    logic [NP-1:0]        e_pop, e_clr, e_free, e_irel, e_cv;
    logic [NP*VCW-1:0]    e_pvc, e_cvc;
    logic [NINT-1:0]      e_lp, e_lt;
    logic [NINT*DW-1:0]   e_ld;
    logic [NINT*VCW-1:0]  e_lv;
    logic [NEJ-1:0]       e_ew, e_et;
    logic [NEJ*DW-1:0]    e_ed;
    logic [NP*NV-1:0]     e_orel;
    logic [PCW-1:0]       e_pass;
    logic [ECW-1:0]       e_ecnt;
    logic                 e_err;

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic base_legal();
        for (int i = 0; i < NP; i++) begin
            s_xv[i] = 0; s_xvc[i] = 0; s_busy[i] = 1; s_up[i] = 1;
            for (int v = 0; v < NV; v++) begin
                s_empty[i][v] = 0; s_data[i][v] = DW'(16'h1000 + i*16 + v);
                s_tail[i][v] = 0; s_act[i][v] = 1; s_port[i][v] = i;
                s_ovc[i][v] = v; s_res[i][v] = 1;
            end
        end
        for (int p = 0; p < NINT; p++) s_occ[p] = 0;
    endtask

    task automatic drive();
        for (int i = 0; i < NP; i++) begin
            xb_valid[i] = s_xv[i];
            xb_vc[i*VCW +: VCW] = VCW'(s_xvc[i]);
            has_upstream[i] = s_up[i];
            outport_busy[i] = s_busy[i];
            for (int v = 0; v < NV; v++) begin
                buf_empty[i*NV+v]  = s_empty[i][v];
                head_data[(i*NV+v)*DW +: DW] = s_data[i][v];
                head_tail[i*NV+v]  = s_tail[i][v];
                ivc_active[i*NV+v] = s_act[i][v];
                ivc_port[(i*NV+v)*PW +: PW] = PW'(s_port[i][v]);
                ivc_ovc[(i*NV+v)*VCW +: VCW] = VCW'(s_ovc[i][v]);
                ovc_reserved[i*NV+v] = s_res[i][v];
            end
        end
        for (int p = 0; p < NINT; p++) link_occ[p*OCW +: OCW] = OCW'(s_occ[p]);
    endtask

    // reference built from R2..R12
    task automatic model();
        logic [NP-1:0] el, cl, g;
        int vc, pt, ov;
        e_pop = '0; e_clr = '0; e_free = '0; e_irel = '0; e_cv = '0;
        e_pvc = '0; e_cvc = '0; e_lp = '0; e_lt = '0; e_ld = '0; e_lv = '0;
        e_ew = '0; e_et = '0; e_ed = '0; e_orel = '0; e_pass = '0; e_ecnt = '0;
        e_err = 1'b0;
        for (int i = 0; i < NP; i++) begin
            vc = s_xvc[i]; pt = s_port[i][vc]; ov = s_ovc[i][vc];
            el[i] = s_xv[i] && !s_empty[i][vc] && s_act[i][vc];
            if (el[i] && pt >= NP) el[i] = 0;
            else if (el[i]) begin
                if (!s_busy[pt]) el[i] = 0;
                if (pt < NINT && s_occ[pt] >= CAP) el[i] = 0;
                if (s_tail[i][vc] && !s_res[pt][ov]) el[i] = 0;
            end
            if (s_xv[i] && !el[i]) e_err = 1'b1;
        end
        for (int i = 0; i < NP; i++) begin
            cl[i] = 0;
            for (int j = 0; j < NP; j++)
                if (j != i && el[i] && el[j] && s_port[i][s_xvc[i]] == s_port[j][s_xvc[j]])
                    cl[i] = 1;
            if (cl[i]) e_err = 1'b1;
        end
        g = el & ~cl;
        for (int i = 0; i < NP; i++) begin
            if (g[i]) begin
                vc = s_xvc[i]; pt = s_port[i][vc]; ov = s_ovc[i][vc];
                e_pop[i] = 1; e_clr[i] = 1; e_free[pt] = 1;
                e_pvc[i*VCW +: VCW] = VCW'(vc);
                e_pass = e_pass + 1'b1;
                if (s_up[i]) begin e_cv[i] = 1; e_cvc[i*VCW +: VCW] = VCW'(vc); end
                if (s_tail[i][vc]) begin e_irel[i] = 1; e_orel[pt*NV + ov] = 1; end
                if (pt < NINT) begin
                    e_lp[pt] = 1; e_lt[pt] = s_tail[i][vc];
                    e_ld[pt*DW +: DW] = s_data[i][vc]; e_lv[pt*VCW +: VCW] = VCW'(ov);
                end else begin
                    e_ew[pt-NINT] = 1; e_et[pt-NINT] = s_tail[i][vc];
                    e_ed[(pt-NINT)*DW +: DW] = s_data[i][vc];
                    e_ecnt = e_ecnt + 1'b1;
                end
            end
        end
    endtask

    task automatic txn(input string tag);
        drive();
        @(posedge clk);
        @(negedge clk);
        model();
        check({tag, " R3"},  "pop_valid",   128'(pop_valid),   128'(e_pop));
        check({tag, " R3"},  "pop_vc",      128'(pop_vc),      128'(e_pvc));
        check({tag, " R4"},  "link_push",   128'(link_push),   128'(e_lp));
        check({tag, " R4"},  "link_data",   128'(link_data),   128'(e_ld));
        check({tag, " R4"},  "link_tail",   128'(link_tail),   128'(e_lt));
        check({tag, " R4"},  "link_vc",     128'(link_vc),     128'(e_lv));
        check({tag, " R5"},  "ej_write",    128'(ej_write),    128'(e_ew));
        check({tag, " R5"},  "ej_data",     128'(ej_data),     128'(e_ed));
        check({tag, " R5"},  "ej_tail",     128'(ej_tail),     128'(e_et));
        check({tag, " R5"},  "eject_count", 128'(eject_count), 128'(e_ecnt));
        check({tag, " R7"},  "xb_clear",    128'(xb_clear),    128'(e_clr));
        check({tag, " R7"},  "port_free",   128'(port_free),   128'(e_free));
        check({tag, " R8"},  "ivc_release", 128'(ivc_release), 128'(e_irel));
        check({tag, " R8"},  "ovc_release", 128'(ovc_release), 128'(e_orel));
        check({tag, " R10"}, "pass_count",  128'(pass_count),  128'(e_pass));
        check({tag, " R11"}, "err",         128'(err),         128'(e_err));
        check({tag, " R9"},  "early credit", 128'(cred_valid), 128'(0));
        for (int i = 0; i < NP; i++) s_xv[i] = 0;
        drive();
        repeat (CAP) @(posedge clk);
        @(negedge clk);
        check({tag, " R9"}, "cred_valid", 128'(cred_valid), 128'(e_cv));
        check({tag, " R9"}, "cred_vc",    128'(cred_vc),    128'(e_cvc));
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        base_legal();
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs stay zero while reset is held
        check("R1", "outputs in reset",
              128'({pop_valid, link_push, ej_write, cred_valid, xb_clear,
                    port_free, ivc_release, ovc_release, pass_count, err}), 128'(0));
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "outputs after reset",
              128'({pop_valid, link_push, ej_write, cred_valid, pass_count, err}), 128'(0));

        // single link push, body flit, on VC 1 toward port 2
        base_legal();
        s_xv[0] = 1; s_xvc[0] = 1; s_port[0][1] = 2; s_ovc[0][1] = 0;
        txn("R4 link");

        // tail flit to port 5, which is ejection interface 1
        base_legal();
        s_xv[3] = 1; s_xvc[3] = 0; s_port[3][0] = 5; s_tail[3][0] = 1; s_ovc[3][0] = 1;
        txn("R5 R8 eject tail");

        // link full blocks, one below full passes
        base_legal();
        s_xv[1] = 1; s_port[1][0] = 3; s_occ[3] = CAP;
        txn("R6 full");
        base_legal();
        s_xv[1] = 1; s_port[1][0] = 3; s_occ[3] = CAP - 1;
        txn("R6 below full");

        // empty buffer and invalid slot
        base_legal();
        s_xv[2] = 1; s_empty[2][0] = 1; s_xv[4] = 0;
        txn("R2 empty");

        // collision on port 1 while input 5 proceeds
        base_legal();
        s_xv[0] = 1; s_port[0][0] = 1; s_xv[2] = 1; s_port[2][0] = 1;
        s_xv[5] = 1; s_port[5][0] = 0;
        txn("R11 R12 collision");

        // every input at once, both ejections, some with no upstream
        base_legal();
        for (int i = 0; i < NP; i++) begin
            s_xv[i] = 1; s_xvc[i] = i % NV; s_port[i][i % NV] = NP - 1 - i;
        end
        s_tail[0][0] = 1; s_up[1] = 0; s_up[4] = 0;
        txn("R12 R9 all");

        // tail without reserved output VC, idle input VC, free output port
        base_legal();
        s_xv[0] = 1; s_tail[0][0] = 1; s_res[0][0] = 0;
        s_xv[1] = 1; s_act[1][0] = 0;
        s_xv[2] = 1; s_busy[2] = 0;
        s_xv[3] = 1; s_port[3][0] = 7;
        s_xv[4] = 1;
        txn("R11 faults");

        for (int t = 0; t < 300; t++) begin
            int perm [NP];
            base_legal();
            for (int k = 0; k < NP; k++) perm[k] = k;
            for (int k = NP - 1; k > 0; k--) begin
                int r = $urandom_range(k);
                int tmp = perm[k];
                perm[k] = perm[r]; perm[r] = tmp;
            end
            for (int i = 0; i < NP; i++) begin
                s_xv[i] = ($urandom_range(3) != 0);
                s_xvc[i] = $urandom_range(NV - 1);
                s_up[i] = ($urandom_range(3) != 0);
                s_busy[i] = ($urandom_range(15) != 0);
                for (int v = 0; v < NV; v++) begin
                    s_empty[i][v] = ($urandom_range(15) == 0);
                    s_data[i][v] = DW'($urandom);
                    s_tail[i][v] = $urandom_range(1);
                    s_act[i][v] = ($urandom_range(15) != 0);
                    s_port[i][v] = $urandom_range(NP - 1);
                    s_ovc[i][v] = $urandom_range(NV - 1);
                    s_res[i][v] = ($urandom_range(15) != 0);
                end
                s_port[i][s_xvc[i]] = perm[i];
                if ($urandom_range(29) == 0) s_port[i][s_xvc[i]] = NP + $urandom_range(1);
            end
            if ($urandom_range(9) == 0) begin
                int i1 = 1 + $urandom_range(NP - 2);
                s_port[i1][s_xvc[i1]] = s_port[0][s_xvc[0]];
            end
            for (int p = 0; p < NINT; p++) s_occ[p] = $urandom_range(CAP);
            txn("R12 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule